// File: doc/BRIEF.md
# Linear Frequency Sweep Accumulator

This block produces the frequency tuning word for a direct digital synthesizer. When sweeping is off, it passes a static tuning word straight through and preloads that word as the starting point of the sweep. When sweeping is on, a down-counting rate timer paces the steps. On each timer expiry, the accumulator either adds the rising delta or subtracts the falling delta, as chosen by a direction input. Programmable upper and lower limit words clamp the result, so the sweep never wraps.

A register-update strobe can restart the rate timer, and it can also zero the accumulator for a single cycle. A separate held clear keeps the accumulator at zero for as long as it is asserted. Register programming and the phase-to-amplitude path are handled elsewhere.

Top module: `freq_sweep_acc`

## Requirements
- R1: While `sweep_en` is 0, `ftw_out` equals `static_ftw` and the accumulator takes no delta steps; the update strobe does not change the output.
- R2: While sweeping, `dir_up`=1 adds `delta_up` at each step and `dir_up`=0 subtracts `delta_dn`.
- R3: The rate timer counts down by one per clock and a step happens only in the cycle it holds 1, so steps are `rate_val` clocks apart (a `rate_val` of 0 or 1 steps every clock); the first step after enabling comes on the `rate_val`-th enabled clock.
- R4: With `rate_reload_on_upd`=1, an `upd_strobe` reloads the timer with `rate_val`; with it 0, the strobe leaves the timer running.
- R5: With `auto_clr_en`=1, an `upd_strobe` zeroes the accumulator for one cycle, after which stepping resumes from zero; with it 0, the strobe leaves the accumulator unchanged.
- R6: While `hold_clr`=1 the accumulator is zero and stays zero; stepping resumes from zero once it drops.
- R7: During and right after reset, with all controls at 0, `ftw_out` equals `static_ftw`.
- R8: An up step that would exceed `lim_hi` yields exactly `lim_hi`, and a down step that would pass below `lim_lo` yields exactly `lim_lo`, including where unsigned arithmetic would otherwise wrap.
- R9: In one cycle, the held clear beats the auto-clear, and both beat a sweep step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_en | input | 1 | Enable linear sweeping |
| dir_up | input | 1 | 1 = ramp up with rising delta, 0 = ramp down with falling delta |
| delta_up | input | FTW_W | Rising delta word |
| delta_dn | input | FTW_W | Falling delta word |
| rate_val | input | RATE_W | Timer reload value (clocks per step) |
| rate_reload_on_upd | input | 1 | Also reload timer on update strobe |
| auto_clr_en | input | 1 | Zero accumulator for one cycle on update strobe |
| hold_clr | input | 1 | Hold accumulator at zero |
| upd_strobe | input | 1 | Register-update pulse |
| static_ftw | input | FTW_W | Static tuning word / sweep start |
| lim_hi | input | FTW_W | Upper saturation word |
| lim_lo | input | FTW_W | Lower saturation word |
| ftw_out | output | FTW_W | Current tuning word |

## Verification
The accumulator and the timer are registers, so every step, clear or reload shows on `ftw_out` one clock edge after the inputs that cause it. The exception is the static pass-through while sweeping is off, which appears in the same cycle. With a rate of N, the first step appears after the Nth enabled edge. A timer reload moves the next step to N edges after the strobe's edge. The bench drives inputs on falling edges and reads `ftw_out` on the falling edge that follows the edge on which the result is due. It counts edges explicitly for each case, rather than polling for the value.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_ZERO = 2'd1,
    ACC_LOAD = 2'd2,
    ACC_STEP = 2'd3
  } acc_op_e;
endpackage

// File: rtl/sweep_rate_timer.sv
module sweep_rate_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              reload_on_upd,
  input  logic              upd_strobe,
  output logic              tick
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  function automatic logic [RATE_W-1:0] eff_rate(input logic [RATE_W-1:0] r);
    return (r == '0) ? ONE : r;
  endfunction

  logic [RATE_W-1:0] cnt_q;
  logic              upd_reload;

  assign upd_reload = reload_on_upd && upd_strobe;
  assign tick       = run && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= ONE;
    else if (!run)                   cnt_q <= eff_rate(rate_val);
    else if (upd_reload || tick)     cnt_q <= eff_rate(rate_val);
    else                             cnt_q <= cnt_q - ONE;
  end

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !upd_reload) |=> (cnt_q == $past(cnt_q) - ONE));

  assert_upd_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && upd_reload) |=> (cnt_q == eff_rate($past(rate_val))));

  assert_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (cnt_q != '0));
endmodule

// File: rtl/sweep_step_acc.sv
module sweep_step_acc
  import fsweep_pkg::*;
#(
  parameter int FTW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sweep_en,
  input  logic             tick,
  input  logic             hold_clr,
  input  logic             auto_clr_en,
  input  logic             upd_strobe,
  input  logic             dir_up,
  input  logic [FTW_W-1:0] delta_up,
  input  logic [FTW_W-1:0] delta_dn,
  input  logic [FTW_W-1:0] static_ftw,
  input  logic [FTW_W-1:0] lim_hi,
  input  logic [FTW_W-1:0] lim_lo,
  output logic [FTW_W-1:0] acc_q
);
  function automatic logic [FTW_W-1:0] sat_add(input logic [FTW_W-1:0] a,
                                               input logic [FTW_W-1:0] d,
                                               input logic [FTW_W-1:0] hi);
    logic [FTW_W:0] s;
    s = {1'b0, a} + {1'b0, d};
    return (s > {1'b0, hi}) ? hi : s[FTW_W-1:0];
  endfunction

  function automatic logic [FTW_W-1:0] sat_sub(input logic [FTW_W-1:0] a,
                                               input logic [FTW_W-1:0] d,
                                               input logic [FTW_W-1:0] lo);
    logic [FTW_W-1:0] r;
    r = a - d;
    return ((a < d) || (r < lo)) ? lo : r;
  endfunction

  acc_op_e          op;
  logic             auto_pulse;
  logic [FTW_W-1:0] step_val;

  assign auto_pulse = auto_clr_en && upd_strobe;
  assign step_val   = dir_up ? sat_add(acc_q, delta_up, lim_hi)
                             : sat_sub(acc_q, delta_dn, lim_lo);

  always_comb begin
    if (hold_clr)        op = ACC_ZERO;
    else if (auto_pulse) op = ACC_ZERO;
    else if (!sweep_en)  op = ACC_LOAD;
    else if (tick)       op = ACC_STEP;
    else                 op = ACC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else begin
      unique case (op)
        ACC_ZERO: acc_q <= '0;
        ACC_LOAD: acc_q <= static_ftw;
        ACC_STEP: acc_q <= step_val;
        default:  acc_q <= acc_q;
      endcase
    end
  end

  assert_hold_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |=> (acc_q == '0));

  assert_auto_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_pulse && tick) |=> (acc_q == '0));

  assert_no_idle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_en && !tick && !hold_clr && !auto_pulse) |=> $stable(acc_q));

  assert_upper_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ACC_STEP && dir_up && acc_q <= lim_hi) |=> (acc_q <= $past(lim_hi)));

  assert_lower_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ACC_STEP && !dir_up && acc_q >= lim_lo) |=> (acc_q >= $past(lim_lo)));
endmodule

// File: rtl/freq_sweep_acc.sv
module freq_sweep_acc #(
  parameter int FTW_W  = 32,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sweep_en,
  input  logic              dir_up,
  input  logic [FTW_W-1:0]  delta_up,
  input  logic [FTW_W-1:0]  delta_dn,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              rate_reload_on_upd,
  input  logic              auto_clr_en,
  input  logic              hold_clr,
  input  logic              upd_strobe,
  input  logic [FTW_W-1:0]  static_ftw,
  input  logic [FTW_W-1:0]  lim_hi,
  input  logic [FTW_W-1:0]  lim_lo,
  output logic [FTW_W-1:0]  ftw_out
);
  logic             step_tick;
  logic [FTW_W-1:0] acc_word;

  sweep_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(sweep_en), .rate_val(rate_val),
    .reload_on_upd(rate_reload_on_upd), .upd_strobe(upd_strobe),
    .tick(step_tick)
  );

  sweep_step_acc #(.FTW_W(FTW_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .tick(step_tick),
    .hold_clr(hold_clr), .auto_clr_en(auto_clr_en), .upd_strobe(upd_strobe),
    .dir_up(dir_up), .delta_up(delta_up), .delta_dn(delta_dn),
    .static_ftw(static_ftw), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .acc_q(acc_word)
  );

  assign ftw_out = sweep_en ? acc_word : static_ftw;

  assert_tick_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_en |-> !step_tick);
endmodule

// File: tb/freq_sweep_acc_bench.sv
module freq_sweep_acc_bench;
  localparam int FW = 32;
  localparam int RW = 8;
  localparam int NV = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, sweep_en, dir_up, rate_reload_on_upd, auto_clr_en, hold_clr, upd_strobe;
  logic [FW-1:0] delta_up, delta_dn, static_ftw, lim_hi, lim_lo, ftw_out;
  logic [RW-1:0] rate_val;

  freq_sweep_acc #(.FTW_W(FW), .RATE_W(RW)) u_freq_sweep_acc (
    .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .dir_up(dir_up),
    .delta_up(delta_up), .delta_dn(delta_dn), .rate_val(rate_val),
    .rate_reload_on_upd(rate_reload_on_upd), .auto_clr_en(auto_clr_en),
    .hold_clr(hold_clr), .upd_strobe(upd_strobe), .static_ftw(static_ftw),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .ftw_out(ftw_out)
  );

  // single-step vectors: start, direction, up delta, down delta, limits, expected
  localparam logic [FW-1:0] V_START[NV] = '{500, 500, 990, 110, 1000, 100, 32'hFFFF_FFF0, 10};
  localparam bit            V_UP   [NV] = '{1, 0, 1, 0, 1, 0, 1, 0};
  localparam logic [FW-1:0] V_DUP  [NV] = '{20, 0, 20, 0, 1, 0, 32'h20, 0};
  localparam logic [FW-1:0] V_DDN  [NV] = '{0, 30, 0, 30, 0, 5, 0, 50};
  localparam logic [FW-1:0] V_HI   [NV] = '{1000, 1000, 1000, 1000, 1000, 1000, 32'hFFFF_FFFF, 1000};
  localparam logic [FW-1:0] V_LO   [NV] = '{100, 100, 100, 100, 100, 100, 0, 0};
  localparam logic [FW-1:0] V_EXP  [NV] = '{520, 470, 1000, 100, 1000, 100, 32'hFFFF_FFFF, 0};

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; sweep_en = 0; dir_up = 1; rate_reload_on_upd = 0; auto_clr_en = 0;
    hold_clr = 0; upd_strobe = 0; delta_up = 0; delta_dn = 0; rate_val = 1;
    static_ftw = 1234; lim_hi = '1; lim_lo = 0;
    tick_n(3);
    chk("R7 output in reset", ftw_out, 1234);
    rst_n = 1;
    tick_n(2);
    chk("R7 output after reset", ftw_out, 1234);

    // vector table: each entry takes exactly one step with rate 1
    for (int i = 0; i < NV; i++) begin
      sweep_en = 0; static_ftw = V_START[i]; dir_up = V_UP[i];
      delta_up = V_DUP[i]; delta_dn = V_DDN[i]; lim_hi = V_HI[i]; lim_lo = V_LO[i];
      tick_n(1);
      sweep_en = 1;
      tick_n(1);
      chk(V_EXP[i] == V_HI[i] || V_EXP[i] == V_LO[i] ? "R8 saturated step" : "R2 one step",
          ftw_out, V_EXP[i]);
      sweep_en = 0;
    end

    // R1: disabled pass-through, update strobe and auto-clear have no visible effect
    static_ftw = 777; auto_clr_en = 1; upd_strobe = 1;
    tick_n(1);
    upd_strobe = 0;
    chk("R1 static pass-through", ftw_out, 777);
    tick_n(3);
    chk("R1 still static", ftw_out, 777);
    auto_clr_en = 0;

    // R3: rate 4, first step on the 4th enabled edge, then every 4
    static_ftw = 0; dir_up = 1; delta_up = 10; lim_hi = '1; lim_lo = 0; rate_val = 4;
    tick_n(2);
    sweep_en = 1;
    tick_n(3);
    chk("R3 no step before timeout", ftw_out, 0);
    tick_n(1);
    chk("R3 first step", ftw_out, 10);
    tick_n(4);
    chk("R3 second step", ftw_out, 20);

    // R4: reload on update delays the next step
    rate_reload_on_upd = 1;
    tick_n(2);
    upd_strobe = 1;
    tick_n(1);
    upd_strobe = 0;
    tick_n(1);
    chk("R4 reload delays step", ftw_out, 20);
    tick_n(3);
    chk("R4 step after reload", ftw_out, 30);

    // R4/R5 negative: strobe leaves timer and accumulator alone
    rate_reload_on_upd = 0;
    tick_n(1);
    upd_strobe = 1;
    tick_n(1);
    upd_strobe = 0;
    tick_n(1);
    chk("R5 strobe without auto-clear keeps value", ftw_out, 30);
    tick_n(1);
    chk("R4 strobe without reload keeps timing", ftw_out, 40);

    // R5 and R9: auto-clear beats a step, then stepping resumes from zero
    sweep_en = 0; static_ftw = 500; rate_val = 1; delta_up = 7; auto_clr_en = 1;
    tick_n(1);
    sweep_en = 1;
    tick_n(2);
    chk("R2 two steps", ftw_out, 514);
    upd_strobe = 1;
    tick_n(1);
    upd_strobe = 0;
    chk("R5 R9 auto-clear over step", ftw_out, 0);
    tick_n(1);
    chk("R5 one-cycle clear then step", ftw_out, 7);

    // R6 and R9: held clear beats steps and the auto-clear pulse
    hold_clr = 1; upd_strobe = 1;
    tick_n(1);
    upd_strobe = 0;
    chk("R6 R9 held clear", ftw_out, 0);
    tick_n(2);
    chk("R6 still held", ftw_out, 0);
    hold_clr = 0;
    tick_n(1);
    chk("R6 resume after release", ftw_out, 7);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule